// File: doc/BRIEF.md
# Serial Bit-Clock and Frame-Sync Generator

This block derives a serial bit clock from one of two sources, the system clock or an external clock pin, by dividing it by a programmable ratio. Alongside the clock level it emits a one-cycle enable, `bclk_tick`, in the system clock domain on every bit-clock period. Serial shift logic elsewhere advances on this enable.

On the same enable it produces a frame-sync signal in one of two modes. In periodic mode a frame counter repeats every (period + 1) bit clocks and holds the sync high for (width + 1) of them. In copy mode a sync pulse one bit clock long follows each strobe from the transmitter that marks a copy from the data register into the shift register.

All settings arrive in one 32-bit configuration word. The clock divider and the frame logic each have their own active-low hold input.

Top module: `sfg_top`

## Requirements
- R1: The configuration word is decoded as follows: bit 29 selects the source (1 = external pin, 0 = system clock), bit 28 selects the frame mode (1 = periodic, 0 = copy-triggered), bits 27:16 hold the frame period P, bits 15:8 hold the pulse width W, and bits 7:0 hold the divider value D. Bits 31:30 are ignored.
- R2: With the system clock selected, `bclk_tick` is asserted for exactly one system clock every D+1 system clocks. With D = 0 it is asserted on every cycle.
- R3: With the external source selected, `ext_clk` passes through a two-stage synchronizer. `bclk_tick` then fires once per D+1 rising edges of `ext_clk`, and it does not fire while `ext_clk` is idle. `ext_clk` must stay at each level for at least two system clocks.
- R4: In steady state with the system clock as source, `bclk` is high for floor((D+1)/2) system clocks and low for the rest of every D+1-cycle period. With D = 0, `bclk` stays low.
- R5: While `gen_rst_n` is low, `bclk` and `bclk_tick` are held low.
- R6: In periodic mode with W < P, `fsync` rises once every P+1 bit-clock ticks and stays high for W+1 ticks.
- R7: When `frm_rst_n` is released, counting starts from zero. `fsync` goes high on the system clock after the first `bclk_tick` that the frame logic consumes.
- R8: While `frm_rst_n` is low, `fsync` is held low and any pending copy request is discarded.
- R9: In copy mode a `copy_stb` pulse makes `fsync` go high at the next tick and stay high for exactly one tick interval. Without a strobe, `fsync` stays low whatever P and W hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal divider source |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| ext_clk | input | 1 | External source clock, asynchronous to `clk` |
| cfg_word | input | 32 | Packed configuration word (see R1) |
| gen_rst_n | input | 1 | Active-low hold of the clock divider |
| frm_rst_n | input | 1 | Active-low hold of the frame logic |
| copy_stb | input | 1 | One-cycle strobe marking a transmit data-to-shift copy |
| bclk | output | 1 | Divided bit-clock level |
| bclk_tick | output | 1 | One-cycle enable per bit-clock period |
| fsync | output | 1 | Frame-sync output |

## Verification
`bclk_tick` and `bclk` come from registers one system clock behind the divider count. `fsync` lags the tick that causes it by one more clock. An external edge reaches the divider three clocks after it is sampled. The bench measures every timing property as a spacing between events: clocks from tick to tick, high samples within a window of D+1 cycles, and ticks counted between `fsync` rises and while `fsync` is high. These counts do not depend on a fixed pipeline offset. All outputs are sampled on the falling edge. For the start after frame release, the tick visible in the release cycle is counted as well, because the frame register consumes it at the next rising edge.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
    localparam int DIV_W    = 8;
    localparam int WID_W    = 8;
    localparam int PER_W    = 12;
    localparam int CFG_W    = 32;
    localparam int DIV_LSB  = 0;
    localparam int WID_LSB  = 8;
    localparam int PER_LSB  = 16;
    localparam int MODE_BIT = 28;
    localparam int SRC_BIT  = 29;

    typedef struct packed {
        logic             src_ext;
        logic             periodic;
        logic [PER_W-1:0] per;
        logic [WID_W-1:0] wid;
        logic [DIV_W-1:0] div;
    } sfg_cfg_t;

    function automatic sfg_cfg_t sfg_decode(input logic [CFG_W-1:0] w);
        sfg_cfg_t c;
        c.src_ext  = w[SRC_BIT];
        c.periodic = w[MODE_BIT];
        c.per      = w[PER_LSB +: PER_W];
        c.wid      = w[WID_LSB +: WID_W];
        c.div      = w[DIV_LSB +: DIV_W];
        return c;
    endfunction
endpackage

// File: rtl/sfg_edge.sv
module sfg_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edge_st_t;

    edge_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[STAGES-2:0], ext_clk};
        s_d.prev = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = s_q.sync[STAGES-1] & ~s_q.prev;

    // R3: one synchronized edge yields a single-cycle pulse
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sfg_div.sv
module sfg_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_rst_n,
    input  logic             src_tick,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             bclk
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             bclk;
        logic             tick;
    } div_st_t;

    div_st_t s_d, s_q;
    logic [DIV_W:0]   ratio;
    logic [DIV_W:0]   low_len;
    logic [DIV_W-1:0] cnt_nx;

    always_comb begin
        ratio   = {1'b0, div} + 1'b1;
        low_len = ratio - (ratio >> 1);
        cnt_nx  = (s_q.cnt >= div) ? '0 : s_q.cnt + 1'b1;
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (!gen_rst_n) begin
            s_d = '0;
        end else if (src_tick) begin
            s_d.cnt  = cnt_nx;
            s_d.tick = (s_q.cnt >= div);
            s_d.bclk = ({1'b0, cnt_nx} >= low_len);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;
    assign bclk = s_q.bclk;

    // R2: the count returns to zero after its terminal value
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_tick && s_q.cnt >= div) |=> (s_q.cnt == '0));
    // R2: a tick needs a source tick on the previous cycle
    p_tick_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(src_tick && gen_rst_n));
    // R5: hold forces clock and enable low
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_rst_n |=> (!tick && !bclk));
endmodule

// File: rtl/sfg_frame.sv
module sfg_frame #(
    parameter int PER_W = 12,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_rst_n,
    input  logic             tick,
    input  logic             periodic,
    input  logic [PER_W-1:0] per,
    input  logic [WID_W-1:0] wid,
    input  logic             copy_stb,
    output logic             fsync
);
    localparam int CMP_W = (PER_W > WID_W) ? PER_W : WID_W;

    typedef struct packed {
        logic [PER_W-1:0] fcnt;
        logic             pend;
        logic             fsync;
    } frm_st_t;

    frm_st_t s_d, s_q;
    logic [CMP_W-1:0] fcnt_x, wid_x;

    always_comb begin
        fcnt_x = CMP_W'(s_q.fcnt);
        wid_x  = CMP_W'(wid);
        s_d    = s_q;
        if (!frm_rst_n) begin
            s_d = '0;
        end else if (!periodic) begin
            s_d.fcnt = '0;
            s_d.pend = s_q.pend | copy_stb;
            if (tick) begin
                s_d.fsync = s_q.pend | copy_stb;
                s_d.pend  = 1'b0;
            end
        end else begin
            s_d.pend = 1'b0;
            if (tick) begin
                s_d.fsync = (fcnt_x <= wid_x);
                s_d.fcnt  = (s_q.fcnt >= per) ? '0 : s_q.fcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fsync = s_q.fsync;

    // R6: frame sync only moves on a bit-clock tick or under hold
    p_fs_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fsync) |-> ($past(tick) || $past(!frm_rst_n)));
    // R8: hold clears the frame sync
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_rst_n |=> !fsync);
    // R9: a strobe between ticks is remembered
    p_copy_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_rst_n && !periodic && copy_stb && !tick) |=> s_q.pend);
endmodule

// File: rtl/sfg_top.sv
module sfg_top
    import sfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             gen_rst_n,
    input  logic             frm_rst_n,
    input  logic             copy_stb,
    output logic             bclk,
    output logic             bclk_tick,
    output logic             fsync
);
    sfg_cfg_t cfg;
    logic     ext_rise;
    logic     src_tick;

    assign cfg      = sfg_decode(cfg_word);
    assign src_tick = cfg.src_ext ? ext_rise : 1'b1;

    sfg_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .rise(ext_rise)
    );

    sfg_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .gen_rst_n(gen_rst_n), .src_tick(src_tick),
        .div(cfg.div), .tick(bclk_tick), .bclk(bclk)
    );

    sfg_frame #(.PER_W(PER_W), .WID_W(WID_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .frm_rst_n(frm_rst_n), .tick(bclk_tick),
        .periodic(cfg.periodic), .per(cfg.per), .wid(cfg.wid),
        .copy_stb(copy_stb), .fsync(fsync)
    );
endmodule

// File: tb/tb_sfg_top.sv
module tb_sfg_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, ext_clk, gen_rst_n, frm_rst_n, copy_stb;
    logic [31:0] cfg_word;
    logic        bclk, bclk_tick, fsync;
    logic        ext_en;
    int          checks = 0;
    int          errors = 0;
    int          ph = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfg_top dut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .cfg_word(cfg_word),
        .gen_rst_n(gen_rst_n), .frm_rst_n(frm_rst_n), .copy_stb(copy_stb),
        .bclk(bclk), .bclk_tick(bclk_tick), .fsync(fsync)
    );

    // external clock: toggles every 3 system clocks when enabled
    initial forever begin
        @(negedge clk);
        if (ext_en) begin
            ph++;
            if (ph == 3) begin ph = 0; ext_clk = ~ext_clk; end
        end
    end

    function automatic logic [31:0] mkcfg(bit src, bit mode, int per, int wid, int dv);
        return {2'b11, src, mode, 12'(per), 8'(wid), 8'(dv)};
    endfunction
    function automatic int exp_space(int dv); return dv + 1; endfunction
    function automatic int exp_high(int dv);  return (dv + 1) / 2; endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick_space(output int sp);
        int c = 0;
        for (int i = 0; i < 3000; i++) begin @(negedge clk); if (bclk_tick) break; end
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk); c++;
            if (bclk_tick) break;
        end
        sp = c;
    endtask

    task automatic high_count(int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin @(negedge clk); if (bclk) h++; end
    endtask

    task automatic restart_gen(logic [31:0] w);
        gen_rst_n = 1'b0; frm_rst_n = 1'b0; cfg_word = w;
        repeat (3) @(negedge clk);
        gen_rst_n = 1'b1;
    endtask

    // ticks from release to first fsync high (tick in the release cycle counts)
    task automatic first_frame(output int n);
        n = 0;
        @(negedge clk);
        frm_rst_n = 1'b1;
        if (bclk_tick) n++;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (fsync) break;
            if (bclk_tick) n++;
        end
    endtask

    // ticks between two fsync rises, and ticks seen while fsync high
    task automatic frame_meas(output int per_t, output int hi_t);
        logic prev;
        per_t = 0; hi_t = 0;
        prev  = fsync;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (fsync && !prev) break;
            prev = fsync;
        end
        prev = 1'b1;
        for (int i = 0; i < 20000; i++) begin
            if (bclk_tick) per_t++;
            if (bclk_tick && fsync) hi_t++;
            @(negedge clk);
            if (fsync && !prev) break;
            prev = fsync;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int sp, h, n, pt, ht, dv, pr, wd, seen;
        void'($urandom(32'd4711));
        rst_n = 1'b0; ext_clk = 1'b0; ext_en = 1'b0; gen_rst_n = 1'b0;
        frm_rst_n = 1'b0; copy_stb = 1'b0; cfg_word = mkcfg(0, 1, 4, 1, 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R5 / R8: both held after reset
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bclk || bclk_tick || fsync) seen++;
        end
        chk(seen == 0, "R5 R8 reset state quiet", seen, 0);

        // R2 / R4 directed corners
        restart_gen(mkcfg(0, 1, 4, 1, 0));
        tick_space(sp); chk(sp == 1, "R2 spacing D=0", sp, 1);
        high_count(8, h); chk(h == 0, "R4 bclk low D=0", h, 0);
        restart_gen(mkcfg(0, 1, 4, 1, 255));
        tick_space(sp); chk(sp == 256, "R2 spacing D=255", sp, 256);
        high_count(256, h); chk(h == 128, "R4 high D=255", h, 128);
        restart_gen(mkcfg(0, 1, 4, 1, 2));
        tick_space(sp); chk(sp == 3, "R2 spacing D=2", sp, 3);
        high_count(3, h); chk(h == 1, "R4 high D=2 odd ratio", h, 1);

        // R5 mid-run hold
        gen_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (bclk || bclk_tick) seen++;
        end
        chk(seen == 0, "R5 hold mid-run", seen, 0);

        // random periodic configurations: R1 R2 R4 R6 R7
        for (int k = 0; k < 8; k++) begin
            dv = $urandom_range(0, 6);
            pr = $urandom_range(1, 9);
            wd = $urandom_range(0, pr - 1);
            restart_gen(mkcfg(0, 1, pr, wd, dv));
            repeat (2 * (dv + 1)) @(negedge clk);
            tick_space(sp);
            chk(sp == exp_space(dv), "R1 R2 random spacing", sp, exp_space(dv));
            high_count(dv + 1, h);
            chk(h == exp_high(dv), "R4 random high count", h, exp_high(dv));
            first_frame(n);
            chk(n == 1, "R7 first frame after release", n, 1);
            frame_meas(pt, ht);
            chk(pt == pr + 1, "R6 frame period", pt, pr + 1);
            chk(ht == wd + 1, "R6 pulse width", ht, wd + 1);
        end

        // R8: frame hold while divider runs
        frm_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        seen = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (fsync) seen++; end
        chk(seen == 0, "R8 fsync held", seen, 0);

        // R9: copy mode, no strobe then one strobe
        restart_gen(mkcfg(0, 0, 2, 1, 3));
        @(negedge clk); frm_rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (fsync) seen++; end
        chk(seen == 0, "R9 no strobe no sync", seen, 0);
        copy_stb = 1'b1; @(negedge clk); copy_stb = 1'b0;
        n = 0;
        for (int i = 0; i < 20; i++) begin if (fsync) break; @(negedge clk); n++; end
        chk(fsync == 1'b1 && n <= 5, "R9 sync follows strobe", n, 5);
        ht = 0;
        for (int i = 0; i < 40; i++) begin
            if (fsync && bclk_tick) ht++;
            @(negedge clk);
        end
        chk(ht == 1, "R9 one tick wide", ht, 1);

        // R8: strobe under hold is discarded
        frm_rst_n = 1'b0;
        copy_stb = 1'b1; @(negedge clk); copy_stb = 1'b0;
        @(negedge clk); frm_rst_n = 1'b1;
        seen = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (fsync) seen++; end
        chk(seen == 0, "R8 strobe discarded under hold", seen, 0);

        // R3: external source
        restart_gen(mkcfg(1, 1, 4, 1, 2));
        seen = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (bclk_tick) seen++; end
        chk(seen == 0, "R3 idle external source", seen, 0);
        ext_en = 1'b1;
        repeat (60) @(negedge clk);
        tick_space(sp); chk(sp == 18, "R3 external spacing D=2", sp, 18);
        tick_space(sp); chk(sp == 18, "R3 external spacing repeat", sp, 18);
        ext_en = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule